// File: doc/BRIEF.md
# Weighted Round Robin Egress Scheduler

This block decides, for each output port of a switch, which queue may put its next frame on the link. Every port has four data queues, one per priority class, and one critical queue for management and control traffic. The buffer manager reports which queues hold frames. The port raises a one-cycle `frame_done` pulse whenever the link is free, either idle or at the end of the previous frame. The scheduler answers on the next cycle with a one-hot grant, and holds that grant until the next pulse.

Control traffic is served in strict priority ahead of all data. The data queues share the link through weighted round robin. Each queue holds a credit counter. The counter is loaded from a weight register when a round begins and drops by one for every frame the queue is granted. A new round starts only when no backlogged queue with a non-zero weight has credit left. Empty queues are passed over, so a lightly loaded link never waits for idle weight. There is one set of four weights, written through a small configuration port, and it applies to every port. Unclassified traffic lands in queue 3, which carries the smallest default weight.

Top module: `wrr_egress_sched`

## Requirements
- R1: After a synchronous active-low reset, every grant bit is 0. The weights of queues 0, 1, 2 and 3 come out of reset as 8, 4, 2 and 1.
- R2: The grant for port p sits at `grant[p*5 +: 5]`. Bit i (0..3) grants data queue i and bit 4 grants the control queue. At most one bit of a port's field is set.
- R3: When `frame_done[p]` is high in a cycle, the new decision for port p appears on `grant` in the following cycle. In every other cycle, port p's grant field keeps its value.
- R4: If the control queue of a port is non-empty at a decision, it is granted whatever the data queues hold, and no data credit is consumed.
- R5: With all four data queues backlogged, every round of (w0+w1+w2+w3) decisions grants each queue exactly as many times as its weight (8/4/2/1 by default).
- R6: At a decision where some data queue is non-empty and has a non-zero weight, a data queue is granted. Empty queues are skipped, and no decision yields an empty grant while such a queue exists.
- R7: A data queue whose weight is 0 is never granted, even if it is non-empty.
- R8: Within a round, the search for the next data queue starts one position after the last queue served and wraps from 3 to 0. A new round searches from queue 0, so four backlogged queues with credit are served 0, 1, 2, 3.
- R9: Writing `cfg_wdata` with `cfg_we` high sets the weight of queue `cfg_sel` for all ports. The new value is loaded into credits at the next round start, and a round already in progress finishes on its old credits.
- R10: A decision made with no queue non-empty drives the port's grant field to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Weight write strobe |
| cfg_sel | input | 2 | Data queue whose weight is written |
| cfg_wdata | input | WW | Weight value |
| q_nonempty | input | NUM_PORTS*4 | Data queue non-empty flags; bit p*4+i is queue i of port p |
| ctrl_nonempty | input | NUM_PORTS | Control queue non-empty flag per port |
| frame_done | input | NUM_PORTS | Link free / previous frame finished; requests a decision |
| grant | output | NUM_PORTS*5 | Per-port one-hot grant fields |

## Verification
The bench builds the scheduler with two ports and 4-bit weights. Two ports are enough to show that one weight bank drives independent per-port credit state, and that stimulus on one port leaves the other port's grant untouched. With 4-bit weights, the default 8/4/2/1 set fits in a 15-decision round, so several complete rounds (ratio, ordering, skip, mid-round reweighting and the following round) can be counted exactly in a short run.

// File: rtl/wrr_pkg.sv
// Package: shared constants and types for the egress scheduler.
// Assumes four data queues per port; the rotating pick needs a power-of-two count.
package wrr_pkg;
    localparam int NQ       = 4;              // data queues per port
    localparam int NG       = NQ + 1;         // grant field width (data + control)
    localparam int CTRL_BIT = NQ;             // control grant bit position
    localparam int QIW      = $clog2(NQ);     // queue index width

    typedef logic [QIW-1:0] qidx_t;

    localparam logic [NG-1:0] CTRL_GRANT = NG'(1) << CTRL_BIT;
endpackage

// File: rtl/wrr_rr_pick.sv
// Rotating first-set finder: returns the first set bit of mask at or after
// position start, wrapping around. Assumes N is a power of two so the index
// wraps by truncation.
module wrr_rr_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [IW-1:0] cand;

    // Scan from farthest to nearest offset so the nearest hit is kept.
    always_comb begin
        found = 1'b0;
        idx   = start;
        cand  = start;
        for (int k = N - 1; k >= 0; k--) begin
            cand = start + IW'(k);
            if (mask[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

endmodule

// File: rtl/wrr_weight_bank.sv
// Global weight registers shared by all ports. Reset loads a halving
// sequence (queue 0 largest). Assumes WW is at least NQ bits wide.
module wrr_weight_bank
    import wrr_pkg::*;
#(
    parameter int WW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  qidx_t            wr_sel,
    input  logic [WW-1:0]    wr_data,
    output logic [NQ*WW-1:0] weights
);

    // Hold the weight set; reset to defaults, update one slot per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                weights[q*WW +: WW] <= WW'(1) << (NQ - 1 - q);
            end
        end else if (wr_en) begin
            weights[wr_sel*WW +: WW] <= wr_data;
        end
    end

endmodule

// File: rtl/wrr_port_arb.sv
// Per-port arbiter: strict-priority control queue above credit-based
// weighted round robin over the data queues. It decides only on a
// frame_done pulse and holds the grant between decisions. Assumes the
// weights are stable across the cycle in which they are loaded.
module wrr_port_arb
    import wrr_pkg::*;
#(
    parameter int WW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ*WW-1:0] weights,
    input  logic [NQ-1:0]    data_ne,
    input  logic             ctrl_ne,
    input  logic             frame_done,
    output logic [NG-1:0]    grant
);

    localparam logic [WW-1:0] CR_ONE  = {{(WW-1){1'b0}}, 1'b1};
    localparam qidx_t         QI_ONE  = qidx_t'(1);
    localparam qidx_t         Q_FIRST = '0;

    logic [WW-1:0] credit_q [NQ];
    logic [WW-1:0] credit_d [NQ];
    qidx_t         ptr_q, ptr_d;
    logic [NG-1:0] grant_q, grant_d;
    logic [NQ-1:0] w_nz, c_nz, live, elig;
    logic          e_found, n_found;
    qidx_t         e_idx, n_idx;

    // Per-queue flags for a non-zero weight and remaining credit.
    for (genvar q = 0; q < NQ; q++) begin : g_flags
        assign w_nz[q] = |weights[q*WW +: WW];
        assign c_nz[q] = |credit_q[q];
    end

    assign live = data_ne & w_nz;
    assign elig = live & c_nz;

    // Continue the current round from the rotating pointer.
    wrr_rr_pick #(.N(NQ)) u_pick_cont (
        .mask  (elig),
        .start (ptr_q),
        .found (e_found),
        .idx   (e_idx)
    );

    // Choose the first queue of a fresh round, searching from queue 0.
    wrr_rr_pick #(.N(NQ)) u_pick_new (
        .mask  (live),
        .start (Q_FIRST),
        .found (n_found),
        .idx   (n_idx)
    );

    // Next-state decision: control first, then in-round, then new round.
    always_comb begin
        credit_d = credit_q;
        ptr_d    = ptr_q;
        grant_d  = grant_q;
        if (frame_done) begin
            if (ctrl_ne) begin
                grant_d = CTRL_GRANT;
            end else if (e_found) begin
                grant_d        = '0;
                grant_d[e_idx] = 1'b1;
                credit_d[e_idx] = credit_q[e_idx] - CR_ONE;
                ptr_d          = e_idx + QI_ONE;
            end else if (n_found) begin
                for (int q = 0; q < NQ; q++) begin
                    credit_d[q] = weights[q*WW +: WW];
                end
                credit_d[n_idx] = weights[n_idx*WW +: WW] - CR_ONE;
                grant_d        = '0;
                grant_d[n_idx] = 1'b1;
                ptr_d          = n_idx + QI_ONE;
            end else begin
                grant_d = '0;
            end
        end
    end

    // Register credits, rotating pointer and grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                credit_q[q] <= '0;
            end
            ptr_q   <= '0;
            grant_q <= '0;
        end else begin
            credit_q <= credit_d;
            ptr_q    <= ptr_d;
            grant_q  <= grant_d;
        end
    end

    assign grant = grant_q;

endmodule

// File: rtl/wrr_egress_sched.sv
// Top: one global weight bank feeding an independent arbiter per output port.
// Assumes queue status is already synchronous to clk.
module wrr_egress_sched
    import wrr_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int WW        = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [QIW-1:0]          cfg_sel,
    input  logic [WW-1:0]           cfg_wdata,
    input  logic [NUM_PORTS*NQ-1:0] q_nonempty,
    input  logic [NUM_PORTS-1:0]    ctrl_nonempty,
    input  logic [NUM_PORTS-1:0]    frame_done,
    output logic [NUM_PORTS*NG-1:0] grant
);

    logic [NQ*WW-1:0] weights_w;

    // Shared weight registers.
    wrr_weight_bank #(.WW(WW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .weights (weights_w)
    );

    // One arbiter per output port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        wrr_port_arb #(.WW(WW)) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .weights    (weights_w),
            .data_ne    (q_nonempty[p*NQ +: NQ]),
            .ctrl_ne    (ctrl_nonempty[p]),
            .frame_done (frame_done[p]),
            .grant      (grant[p*NG +: NG])
        );
    end

endmodule

// File: rtl/wrr_egress_sched_chk.sv
// Checker: temporal properties of the scheduler's grants, bound to the top.
// Reads the shared weight bus to judge zero-weight and work-conserving cases.
module wrr_egress_sched_chk
    import wrr_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int WW        = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_PORTS*NQ-1:0] q_nonempty,
    input logic [NUM_PORTS-1:0]    ctrl_nonempty,
    input logic [NUM_PORTS-1:0]    frame_done,
    input logic [NUM_PORTS*NG-1:0] grant,
    input logic [NQ*WW-1:0]        weights
);

    logic [NQ-1:0] w_nz;
    for (genvar q = 0; q < NQ; q++) begin : g_wnz
        assign w_nz[q] = |weights[q*WW +: WW];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[p*NG +: NG])); // R2

        AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_done[p] |=> $stable(grant[p*NG +: NG])); // R3

        AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            frame_done[p] && ctrl_nonempty[p] |=> grant[p*NG + CTRL_BIT]); // R4

        AST_GRANT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
            frame_done[p] |=> ((grant[p*NG +: NG] &
                $past({ctrl_nonempty[p], q_nonempty[p*NQ +: NQ]})) == grant[p*NG +: NG])); // R6

        AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
            frame_done[p] && |(q_nonempty[p*NQ +: NQ] & w_nz)
            |=> grant[p*NG +: NG] != '0); // R6

        AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            frame_done[p] && !ctrl_nonempty[p] && q_nonempty[p*NQ +: NQ] == '0
            |=> grant[p*NG +: NG] == '0); // R10

        for (genvar q = 0; q < NQ; q++) begin : g_q
            AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
                frame_done[p] && !w_nz[q] |=> !grant[p*NG + q]); // R7
        end
    end

endmodule

bind wrr_egress_sched wrr_egress_sched_chk #(
    .NUM_PORTS (NUM_PORTS),
    .WW        (WW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .q_nonempty    (q_nonempty),
    .ctrl_nonempty (ctrl_nonempty),
    .frame_done    (frame_done),
    .grant         (grant),
    .weights       (weights_w)
);

// File: tb/wrr_egress_sched_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module wrr_egress_sched_bench;
    localparam int NP = 2;
    localparam int WW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_sel = '0;
    logic [WW-1:0]   cfg_wdata = '0;
    logic [NP*4-1:0] q_nonempty = '0;
    logic [NP-1:0]   ctrl_nonempty = '0;
    logic [NP-1:0]   frame_done = '0;
    logic [NP*5-1:0] grant;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    wrr_egress_sched #(.NUM_PORTS(NP), .WW(WW)) u_wrr_egress_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .q_nonempty    (q_nonempty),
        .ctrl_nonempty (ctrl_nonempty),
        .frame_done    (frame_done),
        .grant         (grant)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // 0..3 data queue, 4 control, 7 none, 6 malformed
    function automatic int gidx(input logic [4:0] g);
        case (g)
            5'b00001: return 0;
            5'b00010: return 1;
            5'b00100: return 2;
            5'b01000: return 3;
            5'b10000: return 4;
            5'b00000: return 7;
            default:  return 6;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0;
        q_nonempty = '0;
        ctrl_nonempty = '0;
        frame_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_weight(input int q, input int val);
        cfg_we = 1'b1;
        cfg_sel = 2'(q);
        cfg_wdata = WW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Request one decision on port p; returns decoded grant one cycle later.
    task automatic decide(input int p, output int g);
        frame_done[p] = 1'b1;
        @(negedge clk);
        frame_done[p] = 1'b0;
        g = gidx(grant[p*5 +: 5]);
    endtask

    task automatic t_reset();
        do_reset();
        chk(grant == '0, "R1 grant after reset", int'(grant), 0);
    endtask

    task automatic t_order();
        int g;
        do_reset();
        q_nonempty[3:0] = 4'hF;
        for (int i = 0; i < 4; i++) begin
            decide(0, g);
            chk(g == i, "R8 rotating order", g, i);
        end
    endtask

    task automatic t_ratio();
        int g;
        int cnt[8];
        int exp_w[4] = '{8, 4, 2, 1};
        do_reset();
        q_nonempty[3:0] = 4'hF;
        for (int i = 0; i < 15; i++) begin
            decide(0, g);
            cnt[g]++;
        end
        for (int q = 0; q < 4; q++) begin
            chk(cnt[q] == exp_w[q], "R5 R1 grants per round", cnt[q], exp_w[q]);
        end
        decide(0, g);
        chk(g == 0, "R8 new round restarts at queue 0", g, 0);
    endtask

    task automatic t_ctrl();
        int g;
        do_reset();
        q_nonempty[3:0] = 4'hF;
        ctrl_nonempty[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            decide(0, g);
            chk(g == 4, "R4 control wins", g, 4);
        end
        ctrl_nonempty[0] = 1'b0;
        decide(0, g);
        chk(g == 0, "R4 data resumes at queue 0", g, 0);
    endtask

    task automatic t_hold();
        int g;
        do_reset();
        q_nonempty[3:0] = 4'b0100;
        decide(0, g);
        chk(g == 2, "R3 decision after pulse", g, 2);
        q_nonempty[3:0] = 4'b0001;
        ctrl_nonempty[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            g = gidx(grant[4:0]);
            chk(g == 2, "R3 grant held without pulse", g, 2);
        end
        decide(0, g);
        chk(g == 4, "R3 R4 next pulse picks control", g, 4);
    endtask

    task automatic t_idle_skip();
        int g;
        int cnt[8];
        do_reset();
        decide(0, g);
        chk(g == 7, "R10 empty port gives no grant", g, 7);
        q_nonempty[3:0] = 4'b1000;
        for (int i = 0; i < 5; i++) begin
            decide(0, g);
            chk(g == 3, "R6 lone queue served every decision", g, 3);
        end
        do_reset();
        q_nonempty[3:0] = 4'b0101;
        for (int i = 0; i < 10; i++) begin
            decide(0, g);
            cnt[g]++;
        end
        chk(cnt[0] == 8, "R6 skip empty: queue 0 count", cnt[0], 8);
        chk(cnt[2] == 2, "R6 skip empty: queue 2 count", cnt[2], 2);
        chk(cnt[7] == 0, "R6 no empty grant while backlogged", cnt[7], 0);
    endtask

    task automatic t_zero();
        int g;
        do_reset();
        wr_weight(1, 0);
        q_nonempty[3:0] = 4'b0010;
        decide(0, g);
        chk(g == 7, "R7 zero-weight queue alone not served", g, 7);
        q_nonempty[3:0] = 4'b0110;
        for (int i = 0; i < 4; i++) begin
            decide(0, g);
            chk(g == 2, "R7 zero-weight queue passed over", g, 2);
        end
    endtask

    task automatic t_global();
        int g;
        int cnt[8];
        int cnt2[8];
        int exp_w[4] = '{8, 4, 2, 1};
        do_reset();
        q_nonempty[7:4] = 4'hF;
        for (int i = 0; i < 15; i++) begin
            decide(1, g);
            cnt[g]++;
        end
        for (int q = 0; q < 4; q++) begin
            chk(cnt[q] == exp_w[q], "R9 second port uses shared weights", cnt[q], exp_w[q]);
        end
        chk(grant[4:0] == '0, "R9 other port untouched", int'(grant[4:0]), 0);
        do_reset();
        q_nonempty[3:0] = 4'hF;
        decide(0, g);
        wr_weight(0, 2);
        for (int q = 0; q < 8; q++) cnt[q] = 0;
        for (int i = 0; i < 14; i++) begin
            decide(0, g);
            cnt[g]++;
        end
        chk(cnt[0] == 7, "R9 round in progress keeps old credit", cnt[0], 7);
        chk(cnt[3] == 1, "R9 round in progress queue 3", cnt[3], 1);
        for (int i = 0; i < 9; i++) begin
            decide(0, g);
            cnt2[g]++;
        end
        chk(cnt2[0] == 2, "R9 new weight in next round", cnt2[0], 2);
        chk(cnt2[1] == 4, "R9 next round queue 1", cnt2[1], 4);
    endtask

    initial begin
        t_reset();
        t_order();
        t_ratio();
        t_ctrl();
        t_hold();
        t_idle_skip();
        t_zero();
        t_global();
        summary();
        $finish;
    end

endmodule